// File: doc/BRIEF.md
# Waveform Zero-Suppression Filter

This block sits in the readout path of one digitizer channel. For each trigger it receives the channel's waveform as a stream of signed 16-bit samples framed by start and end markers. It stores the waveform and measures a baseline from its opening samples. It then scans the stored samples for any sample that strays from that baseline by more than a programmable signed threshold. From that scan it decides whether the waveform is worth keeping. A kept waveform is replayed only up to the last significant sample plus a programmable tail. A suppressed waveform produces nothing but its closing status word.

Every waveform ends with exactly one footer word. The footer reports the suppression mode, the keep decision, the index of the last replayed sample and the measured baseline, so the downstream packet builder can close its packet without any other side information. A control word enables suppression, can force the keep decision, sets the tail length and can abort the block at any time.

Top module: `wave_zero_suppress`

## Requirements
- R1: With control bit 0 clear, every sample of the waveform is emitted in order, followed by the footer with bit 29 = 0, bit 28 = 1 and bits 27..16 = N-1, where N is the sample count.
- R2: The baseline is the floor of the mean of the first 8 samples and appears in footer bits 15..0 as a two's-complement value.
- R3: With suppression enabled, a sample is significant when |sample - baseline| is strictly greater than the signed threshold; deviations of either sign qualify, and a deviation equal to the threshold does not.
- R4: When at least one sample is significant, the emitted samples are indices 0 through keepLast, where keepLast = last significant index + control bits 27..16, limited to N-1; footer bits 27..16 carry keepLast.
- R5: With suppression enabled, no significant sample and control bit 1 clear, only the footer is emitted, with bit 28 = 0 and bits 27..16 = 0.
- R6: With control bit 1 set and no significant sample, the whole waveform is emitted and the footer shows bit 28 = 1 and bits 27..16 = N-1.
- R7: The footer word always has bits 31 and 30 set and bit 29 equal to the suppression enable that applied to that waveform.
- R8: Each waveform produces exactly one footer, flagged by outIsFooter = 1, after its last emitted sample; no output word appears without an input waveform.
- R9: While control bit 31 is set, the block abandons any waveform in progress and emits nothing from the next cycle on; after it clears, the next waveform is processed normally.
- R10: The control word and the threshold are captured with the first sample of a waveform; changes made later in that waveform do not affect its result.
- R11: Emitted samples leave on consecutive cycles in ascending index order; sample words carry the sample in bits 15..0 and zero in bits 31..16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample valid |
| inStart | input | 1 | Marks the first sample of a waveform |
| inEnd | input | 1 | Marks the last sample of a waveform |
| inSample | input | 16 | Signed input sample |
| threshold | input | 16 | Signed significance threshold |
| ctrlWord | input | 32 | Bit 0 enable, bit 1 force keep, bits 27..16 tail length, bit 31 abort |
| outValid | output | 1 | Output word valid |
| outIsFooter | output | 1 | Output word is the footer |
| outData | output | 32 | Sample word or footer word |

## Verification
The assertions take for granted that a new waveform starts only after the footer of the previous one has left the block. They also assume each waveform holds at least 8 and at most DEPTH samples, with inValid held high from start to end marker. The bench keeps to this by waiting for its expected-word queue to empty before driving the next waveform. It drives every sample on consecutive cycles and uses lengths between 12 and 40 samples. The only waveform that breaks the framing is the one cut short on purpose by the abort bit, after which no further samples of it are sent.

// File: rtl/wzsPkg.sv
package wzsPkg;

  typedef logic [11:0] idx_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPT,
    ST_SCAN,
    ST_SETTLE,
    ST_DECIDE,
    ST_EMIT,
    ST_FOOT
  } wzsState_t;

  typedef struct packed {
    logic clr;
    logic start;
    logic wrEn;
    idx_t wrAddr;
    logic rdEn;
    idx_t rdAddr;
    logic scanRd;
    logic emitRd;
    logic footStb;
  } wzsStrobe_t;

endpackage

// File: rtl/wzs_ctrl.sv
module wzs_ctrl
  import wzsPkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       inValid,
  input  logic       inStart,
  input  logic       inEnd,
  input  logic       keepBit,
  input  idx_t       keepLast,
  output wzsStrobe_t stb,
  output idx_t       nLast
);

  wzsState_t state;
  idx_t      wrCnt;
  idx_t      rdCnt;
  logic      startNow;

  assign startNow = (state == ST_IDLE) && inValid && inStart && !softRst;

  always_comb begin
    stb         = '0;
    stb.clr     = softRst;
    stb.start   = startNow;
    stb.wrEn    = !softRst && inValid &&
                  ((state == ST_IDLE && inStart) || state == ST_CAPT);
    stb.wrAddr  = (state == ST_IDLE) ? '0 : wrCnt;
    stb.scanRd  = (state == ST_SCAN) && !softRst;
    stb.emitRd  = (state == ST_EMIT) && !softRst;
    stb.rdEn    = stb.scanRd || stb.emitRd;
    stb.rdAddr  = rdCnt;
    stb.footStb = (state == ST_FOOT) && !softRst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      wrCnt <= '0;
      rdCnt <= '0;
      nLast <= '0;
    end else if (softRst) begin
      state <= ST_IDLE;
      wrCnt <= '0;
      rdCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startNow) begin
            wrCnt <= idx_t'(1);
            rdCnt <= '0;
            if (inEnd) begin
              nLast <= '0;
              state <= ST_SCAN;
            end else begin
              state <= ST_CAPT;
            end
          end
        end
        ST_CAPT: begin
          if (inValid) begin
            wrCnt <= wrCnt + idx_t'(1);
            if (inEnd) begin
              nLast <= wrCnt;
              rdCnt <= '0;
              state <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          rdCnt <= rdCnt + idx_t'(1);
          if (rdCnt == nLast) state <= ST_SETTLE;
        end
        ST_SETTLE: state <= ST_DECIDE;
        ST_DECIDE: begin
          rdCnt <= '0;
          state <= keepBit ? ST_EMIT : ST_FOOT;
        end
        ST_EMIT: begin
          rdCnt <= rdCnt + idx_t'(1);
          if (rdCnt == keepLast) state <= ST_FOOT;
        end
        ST_FOOT: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Replay only happens for a kept waveform (R5).
  assert_emit_needs_keep_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EMIT) |-> keepBit);

  // Replay never runs past the final captured sample (R4).
  assert_emit_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EMIT) |-> (rdCnt <= nLast));

  // Abort drives the sequencer back to idle (R9).
  assert_abort_idles_R9: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (state == ST_IDLE));

endmodule

// File: rtl/wzs_datapath.sv
module wzs_datapath
  import wzsPkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int BASE_LOG2 = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  wzsStrobe_t  stb,
  input  logic [15:0] inSample,
  input  logic [15:0] threshold,
  input  logic [31:0] ctrlWord,
  input  idx_t        nLast,
  output logic        keepBit,
  output idx_t        keepLast,
  output logic        outValid,
  output logic        outIsFooter,
  output logic [31:0] outData
);

  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ACCW   = 16 + BASE_LOG2;
  localparam int BASE_N = 1 << BASE_LOG2;

  logic [15:0]      mem [DEPTH];
  logic [15:0]      rdData;
  logic [ACCW-1:0]  accum;
  logic [15:0]      baseline;
  logic             enQ, forceQ;
  idx_t             keepMoreQ;
  logic [15:0]      thrQ;
  logic             scanQ, emitQ, footQ;
  idx_t             rdAddrQ;
  logic             sigFound;
  idx_t             lastSig;
  logic signed [16:0] diff;
  logic [16:0]      mag;
  logic             sigNow;
  logic [12:0]      tailSum;
  idx_t             tailClamped;

  // Sample buffer
  always_ff @(posedge clk) begin
    if (stb.wrEn) mem[stb.wrAddr[AW-1:0]] <= inSample;
    if (stb.rdEn) rdData <= mem[stb.rdAddr[AW-1:0]];
  end

  // Baseline accumulation and settings capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accum     <= '0;
      enQ       <= 1'b0;
      forceQ    <= 1'b0;
      keepMoreQ <= '0;
      thrQ      <= '0;
    end else begin
      if (stb.start) begin
        accum     <= {{BASE_LOG2{inSample[15]}}, inSample};
        enQ       <= ctrlWord[0];
        forceQ    <= ctrlWord[1];
        keepMoreQ <= ctrlWord[27:16];
        thrQ      <= threshold;
      end else if (stb.wrEn && (stb.wrAddr < idx_t'(BASE_N))) begin
        accum <= accum + {{BASE_LOG2{inSample[15]}}, inSample};
      end
    end
  end

  assign baseline = accum[ACCW-1:BASE_LOG2];

  // Significance test
  always_comb begin
    diff   = $signed({rdData[15], rdData}) - $signed({baseline[15], baseline});
    mag    = diff[16] ? 17'(-diff) : 17'(diff);
    sigNow = $signed({1'b0, mag}) > $signed({{2{thrQ[15]}}, thrQ});
  end

  // Pipeline flags and significance tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanQ    <= 1'b0;
      emitQ    <= 1'b0;
      footQ    <= 1'b0;
      rdAddrQ  <= '0;
      sigFound <= 1'b0;
      lastSig  <= '0;
    end else if (stb.clr) begin
      scanQ    <= 1'b0;
      emitQ    <= 1'b0;
      footQ    <= 1'b0;
      sigFound <= 1'b0;
    end else begin
      scanQ <= stb.scanRd;
      emitQ <= stb.emitRd;
      footQ <= stb.footStb;
      if (stb.rdEn) rdAddrQ <= stb.rdAddr;
      if (stb.start) begin
        sigFound <= 1'b0;
        lastSig  <= '0;
      end else if (scanQ && enQ && sigNow) begin
        sigFound <= 1'b1;
        lastSig  <= rdAddrQ;
      end
    end
  end

  // Keep decision
  always_comb begin
    tailSum     = {1'b0, lastSig} + {1'b0, keepMoreQ};
    tailClamped = (tailSum > {1'b0, nLast}) ? nLast : tailSum[11:0];
    if (!enQ) begin
      keepBit  = 1'b1;
      keepLast = nLast;
    end else if (sigFound) begin
      keepBit  = 1'b1;
      keepLast = tailClamped;
    end else if (forceQ) begin
      keepBit  = 1'b1;
      keepLast = nLast;
    end else begin
      keepBit  = 1'b0;
      keepLast = '0;
    end
  end

  assign outValid    = emitQ || footQ;
  assign outIsFooter = footQ;
  assign outData     = footQ ? {2'b11, enQ, keepBit, keepLast, baseline}
                             : {16'h0000, rdData};

  // Abort silences the output from the next cycle (R9).
  assert_abort_silences_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> !outValid);

  // A footer is never followed directly by another footer (R8).
  assert_single_footer_R8: assert property (@(posedge clk) disable iff (!rstN)
    footQ |=> !footQ);

  // Replayed samples advance by one index per cycle (R11).
  assert_ascending_order_R11: assert property (@(posedge clk) disable iff (!rstN)
    (emitQ && $past(emitQ)) |-> (rdAddrQ == $past(rdAddrQ) + idx_t'(1)));

endmodule

// File: rtl/wave_zero_suppress.sv
module wave_zero_suppress
  import wzsPkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int BASE_LOG2 = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inStart,
  input  logic        inEnd,
  input  logic [15:0] inSample,
  input  logic [15:0] threshold,
  input  logic [31:0] ctrlWord,
  output logic        outValid,
  output logic        outIsFooter,
  output logic [31:0] outData
);

  wzsStrobe_t stb;
  idx_t       nLast;
  idx_t       keepLast;
  logic       keepBit;

  wzs_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .softRst  (ctrlWord[31]),
    .inValid  (inValid),
    .inStart  (inStart),
    .inEnd    (inEnd),
    .keepBit  (keepBit),
    .keepLast (keepLast),
    .stb      (stb),
    .nLast    (nLast)
  );

  wzs_datapath #(.DEPTH(DEPTH), .BASE_LOG2(BASE_LOG2)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .inSample    (inSample),
    .threshold   (threshold),
    .ctrlWord    (ctrlWord),
    .nLast       (nLast),
    .keepBit     (keepBit),
    .keepLast    (keepLast),
    .outValid    (outValid),
    .outIsFooter (outIsFooter),
    .outData     (outData)
  );

  // Every footer carries its two marker bits (R7).
  assert_footer_marker_R7: assert property (@(posedge clk) disable iff (!rstN)
    outIsFooter |-> (outValid && outData[31:30] == 2'b11));

endmodule

// File: tb/wave_zero_suppress_tb.sv
module wave_zero_suppress_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inStart = 1'b0;
  logic        inEnd = 1'b0;
  logic [15:0] inSample = '0;
  logic [15:0] threshold = '0;
  logic [31:0] ctrlWord = '0;
  logic        outValid;
  logic        outIsFooter;
  logic [31:0] outData;

  int checks = 0;
  int fails = 0;
  bit doneFlag = 0;

  logic [32:0] expQ[$];
  string       tagQ[$];
  logic signed [15:0] wave [256];

  always #4 clk = ~clk;

  wave_zero_suppress dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart), .inEnd(inEnd),
    .inSample(inSample), .threshold(threshold), .ctrlWord(ctrlWord),
    .outValid(outValid), .outIsFooter(outIsFooter), .outData(outData)
  );

  task automatic checkVal(string tag, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishTest();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: pops and compares as words appear
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        checkVal("R8 unexpected output", {outIsFooter, outData}, 33'h0);
        if ({outIsFooter, outData} == 33'h0) begin
          fails++;
          $display("FAIL R8: unexpected zero word, actual %h expected none", outData);
        end
      end else begin
        logic [32:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkVal(t, {outIsFooter, outData}, e);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishTest();
    end
  end

  task automatic fillWave(int n, int base, bit noisy);
    for (int i = 0; i < n; i++)
      wave[i] = 16'(base + (noisy ? ((i * 7) % 5) - 2 : 0));
  endtask

  task automatic pushExpected(int n, logic [31:0] ctl, int thr, string tag);
    int sum, base, d, last, kl;
    bit found, keep;
    sum = 0;
    for (int i = 0; i < 8; i++) sum += int'(wave[i]);
    base = sum >>> 3;
    found = 0;
    last = 0;
    for (int i = 0; i < n; i++) begin
      d = int'(wave[i]) - base;
      if (d < 0) d = -d;
      if (d > thr) begin found = 1; last = i; end
    end
    if (!ctl[0]) begin keep = 1; kl = n - 1; end
    else if (found) begin
      keep = 1;
      kl = last + int'(ctl[27:16]);
      if (kl > n - 1) kl = n - 1;
    end else if (ctl[1]) begin keep = 1; kl = n - 1; end
    else begin keep = 0; kl = 0; end
    if (keep)
      for (int i = 0; i <= kl; i++) begin
        expQ.push_back({1'b0, 16'h0000, wave[i]});
        tagQ.push_back(tag);
      end
    expQ.push_back({1'b1, 2'b11, ctl[0], keep, 12'(kl), 16'(base)});
    tagQ.push_back(tag);
  endtask

  task automatic driveWave(int n, logic [31:0] ctlAfter, logic [15:0] thrAfter, bit change);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (change && i == 1) begin ctrlWord = ctlAfter; threshold = thrAfter; end
      inValid  = 1'b1;
      inStart  = (i == 0);
      inEnd    = (i == n - 1);
      inSample = wave[i];
    end
    @(negedge clk);
    inValid = 1'b0; inStart = 1'b0; inEnd = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic runWave(int n, logic [31:0] ctl, int thr, string tag);
    @(negedge clk);
    ctrlWord  = ctl;
    threshold = 16'(thr);
    pushExpected(n, ctl, thr, tag);
    driveWave(n, ctl, 16'(thr), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkVal("R8 reset outValid", {32'h0, outValid}, 33'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkVal("R8 idle outValid", {32'h0, outValid}, 33'h0);

    // R1: suppression off, everything passes
    fillWave(20, 300, 1);
    wave[10] = 16'sd900;
    runWave(20, 32'h0000_0000, 10, "R1 passthrough");

    // R3/R4: positive pulse, tail of 3 (tail field bits 27..16)
    fillWave(30, 200, 1);
    wave[12] = 16'sd400;
    runWave(30, 32'h0003_0001, 50, "R4 positive pulse tail");

    // R3: negative pulse detected
    fillWave(24, 200, 1);
    wave[10] = 16'sd50;
    runWave(24, 32'h0002_0001, 50, "R3 negative pulse");

    // R4: tail clamped at the last sample
    fillWave(16, -40, 1);
    wave[14] = 16'sd500;
    runWave(16, 32'h000A_0001, 30, "R4 clamp");

    // R5: quiet waveform suppressed
    fillWave(20, 1000, 1);
    runWave(20, 32'h0005_0001, 20, "R5 suppressed");

    // R6: forced keep of quiet waveform
    fillWave(18, 1000, 1);
    runWave(18, 32'h0005_0003, 20, "R6 forced keep");

    // R3: deviation equal to threshold is not significant
    fillWave(20, 100, 0);
    wave[15] = 16'sd150;
    runWave(20, 32'h0001_0001, 50, "R3 equal threshold");

    // R3: one count above threshold is significant
    fillWave(20, 100, 0);
    wave[15] = 16'sd151;
    runWave(20, 32'h0001_0001, 50, "R3 above threshold");

    // R2: negative baseline with a non-multiple-of-8 sum rounds down
    fillWave(12, -1003, 1);
    wave[0] = -16'sd1000;
    runWave(12, 32'h0000_0001, 4000, "R2 baseline floor");

    // R7: footer markers with enable set and negative threshold (all significant)
    fillWave(14, 10, 1);
    runWave(14, 32'h0000_0001, -1, "R7 footer markers");

    // R10: settings changed after the first sample have no effect
    fillWave(22, 500, 1);
    wave[9] = 16'sd700;
    @(negedge clk);
    ctrlWord  = 32'h0001_0001;
    threshold = 16'd40;
    pushExpected(22, 32'h0001_0001, 40, "R10 late change");
    driveWave(22, 32'h0000_0002, 16'd1000, 1);

    // R9: abort in the middle of capture
    @(negedge clk);
    ctrlWord  = 32'h0000_0001;
    threshold = 16'd10;
    fillWave(20, 0, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      inValid = 1'b1; inStart = (i == 0); inEnd = 1'b0; inSample = wave[i];
    end
    @(negedge clk);
    inValid = 1'b0; inStart = 1'b0;
    ctrlWord = 32'h8000_0001;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checkVal("R9 silent during abort", {32'h0, outValid}, 33'h0);
    end
    ctrlWord = 32'h0000_0001;
    repeat (5) @(negedge clk);
    checkVal("R9 silent after abort", {32'h0, outValid}, 33'h0);
    fillWave(20, 250, 1);
    wave[11] = 16'sd10;
    runWave(20, 32'h0002_0001, 30, "R9 after abort");

    // R11: longer waveform replayed in order
    fillWave(40, -2000, 1);
    wave[30] = -16'sd3000;
    runWave(40, 32'h0004_0001, 100, "R11 long replay");

    repeat (5) @(negedge clk);
    checkVal("R8 queue drained", 33'(expQ.size()), 33'h0);
    doneFlag = 1;
    finishTest();
  end

endmodule